// File: doc/BRIEF.md
# Split-Mode Event Counter Block

This block counts hardware events on four physical counters and exposes them through a small memory-mapped register window. Each physical counter runs either as one 32-bit count or as two independent 16-bit halves, so software sees up to eight logical counters. A per-counter size bit in the control register picks the mode. When a count wraps from all ones to zero, a status bit is set. A single level interrupt is raised while any status bit is also enabled in the interrupt mask.

Software never writes a running count directly. A counter write loads a holding latch and sets a pending flag. While the flag is set, reads of that counter return the latched value. Writing the control register with the enable bit set copies every pending latch into its live counter in one cycle and clears all pending flags. This happens even when the block is already enabled, so software re-arms the counters by rewriting the control word. Reading the status register returns the pending overflow bits and clears them in the same access.

Every register is 32 bits wide and sits in the upper half of a 64-bit bus slot. The lower half of the bus is ignored on writes and reads back as zero.

Top module: `perf_ctr_unit`

## Requirements
- R1: After reset the control word, the status bits, the interrupt mask, every live counter, every latch and every pending flag are zero, `irq` is low and `bus_rdata` is zero.
- R2: The slot index is `bus_addr[7:3]`. Slot 0 holds the control word, slot 1 holds the status and mask register, and slots 2 to 9 hold logical counters 0 to 7. Register data travels in `bus_wdata[63:32]` and `bus_rdata[63:32]`, and `bus_rdata[31:0]` is always zero. Read data appears on `bus_rdata` one cycle after the `bus_rd` strobe and holds until the next read. An unmapped slot reads as zero.
- R3: In the control word, bit 0 is the enable bit and bit 4+i (i = 0..3) is the size bit of physical counter i, where 1 means two 16-bit halves. All other bits are not stored and read back as zero.
- R4: While the enable bit is set, a physical counter in 32-bit mode adds one on every clock edge at which `event_in[i]` is high, and `event_in[4+i]` has no effect on it. While the enable bit is clear, no counter changes on events.
- R5: In 16-bit mode, `event_in[i]` advances the upper half and `event_in[4+i]` advances the lower half. A wrap of the lower half never carries into the upper half.
- R6: Logical counter n (n < 4) reads the full 32-bit value in 32-bit mode and the upper half, zero-extended, in 16-bit mode. Logical counter 4+i always reads the lower half of physical counter i, zero-extended. A write to a logical counter changes only the bits that the logical counter reads.
- R7: A counter write loads only the holding latch and sets the pending flag. The live count keeps running, and reads return the latched value while the flag is set.
- R8: A control write with bit 0 set copies every pending latch into its live counter and clears all pending flags, even when the block is already enabled. In that cycle the committed value wins over a same-cycle event.
- R9: When a 32-bit counter i or the upper half of counter i wraps from all ones to zero, status bit i is set. When the lower half of counter i wraps, status bit 4+i is set.
- R10: A status read returns the pending status bits and clears them. An overflow in the same cycle as the read stays set for the next read. A status write does not change the status bits.
- R11: A status write stores `bus_wdata[39:32]` as the interrupt mask. `irq` is high while any status bit is set together with its mask bit, and writing zero masks everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address; bits [7:3] select the slot |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 64 | Write data; register value in [63:32] |
| bus_rdata | output | 64 | Registered read data; value in [63:32] |
| event_in | input | 8 | Event lines, one per logical counter |
| irq | output | 1 | Level interrupt: masked status pending |

## Verification
Register writes and counter commits take effect at the clock edge that samples the write strobe. Read data is registered at the edge that samples `bus_rd`, so the bench raises the strobe at a falling edge and picks up `bus_rdata` at the next falling edge. An event line held high across n rising edges adds exactly n. For that reason the bench drives events only on falling edges and reads a counter only after the event window has closed. The `irq` output follows the status and mask registers without extra delay, so it is checked at the falling edge right after the write or overflow that changes it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Slot numbering of the register window (slot = byte address / 8).
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_STAT = 1;
  localparam int SLOT_CTR0 = 2;
  // Control word field positions.
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SPLIT_LSB = 4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_STAT,
    ACC_CTR
  } acc_kind_e;
endpackage

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split,
  input  logic             count_en,
  input  logic             ev_hi,
  input  logic             ev_lo,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_val,
  input  logic             commit,
  output logic [CTR_W-1:0] live,
  output logic [CTR_W-1:0] latch_val,
  output logic             pend,
  output logic             ovf_hi,
  output logic             ovf_lo
);
  localparam int HALF_W = CTR_W / 2;

  logic              take;
  logic              inc_hi;
  logic              inc_lo;
  logic [HALF_W-1:0] up_half;
  logic [HALF_W-1:0] lo_half;

  assign up_half = live[CTR_W-1:HALF_W];
  assign lo_half = live[HALF_W-1:0];

  // A commit of a pending latch overrides any increment in that cycle.
  assign take   = commit & pend;
  assign inc_hi = count_en & ev_hi & ~take;
  assign inc_lo = count_en & ev_lo & split & ~take;

  function automatic logic [CTR_W-1:0] advance(
    input logic [CTR_W-1:0] cur,
    input logic             sp,
    input logic             ih,
    input logic             il
  );
    logic [HALF_W-1:0] u;
    logic [HALF_W-1:0] l;
    if (sp) begin
      u = cur[CTR_W-1:HALF_W] + HALF_W'(ih);
      l = cur[HALF_W-1:0] + HALF_W'(il);
      return {u, l};
    end
    return cur + CTR_W'(ih);
  endfunction

  assign ovf_hi = inc_hi & (split ? (&up_half) : (&live));
  assign ovf_lo = inc_lo & (&lo_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
    end else if (take) begin
      live <= latch_val;
    end else begin
      live <= advance(live, split, inc_hi, inc_lo);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_val <= '0;
      pend      <= 1'b0;
    end else if (wr_en) begin
      latch_val <= wr_val;
      pend      <= 1'b1;
    end else if (commit) begin
      pend      <= 1'b0;
    end
  end

  // R7: a staged write alone never moves the live count
  p_live_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inc_hi && !inc_lo) |=> $stable(live));

  // R8: a commit loads exactly the latched value
  p_commit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (live == $past(latch_val)));

  // R5: without an upper event the upper half holds in split mode
  p_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !take && !inc_hi) |=> $stable(up_half));
endmodule

// File: rtl/pcu_status.sv
module pcu_status #(
  parameter int NUM_LOG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOG-1:0] ovf_set,
  input  logic               rd_clr,
  input  logic               mask_wr,
  input  logic [NUM_LOG-1:0] mask_val,
  output logic [NUM_LOG-1:0] status,
  output logic [NUM_LOG-1:0] mask,
  output logic               irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (rd_clr ? '0 : status) | ovf_set;
      if (mask_wr) mask <= mask_val;
    end
  end

  assign irq = |(status & mask);

  // R9: every reported wrap is visible in the status bits next cycle
  p_ovf_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_set) |=> ((status & $past(ovf_set)) == $past(ovf_set)));

  // R10: a read with no concurrent wrap leaves status empty
  p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (ovf_set == '0)) |=> (status == '0));

  // R11: an all-zero mask silences the interrupt
  p_mask_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && (mask_val == '0)) |=> !irq);
endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import pcu_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int CTR_W    = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [2*CTR_W-1:0]    bus_wdata,
  output logic [2*CTR_W-1:0]    bus_rdata,
  input  logic [2*NUM_PHYS-1:0] event_in,
  output logic                  irq
);
  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int HALF_W  = CTR_W / 2;
  localparam int BUS_W   = 2 * CTR_W;
  localparam int SLOT_W  = ADDR_W - 3;
  localparam int PIDX_W  = $clog2(NUM_PHYS);
  localparam logic [CTR_W-1:0] CTRL_MASK =
    CTR_W'(((1 << NUM_PHYS) - 1) << CTRL_SPLIT_LSB) | CTR_W'(1 << CTRL_EN_BIT);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lidx;
  logic [PIDX_W-1:0] pidx;
  logic              lo_sel;
  acc_kind_e         kind;
  logic [CTR_W-1:0]  wv;
  logic [CTR_W-1:0]  ctrl_q;
  logic [CTR_W-1:0]  rsel;
  logic [BUS_W-1:0]  rdata_q;
  logic              commit;
  logic              count_en;
  logic              stat_rd;
  logic              mask_wr;

  logic [NUM_PHYS-1:0] split;
  logic [NUM_PHYS-1:0] pend;
  logic [NUM_PHYS-1:0] wr_hit;
  logic [NUM_LOG-1:0]  ovf_set;
  logic [NUM_LOG-1:0]  status;
  logic [NUM_LOG-1:0]  mask;
  logic [CTR_W-1:0]    live    [NUM_PHYS];
  logic [CTR_W-1:0]    latch_v [NUM_PHYS];
  logic [CTR_W-1:0]    cur     [NUM_PHYS];
  logic [CTR_W-1:0]    wr_val  [NUM_PHYS];

  // What a logical counter shows of its physical counter.
  function automatic logic [CTR_W-1:0] lview(
    input logic [CTR_W-1:0] c,
    input logic             lo,
    input logic             sp
  );
    if (lo) return {{HALF_W{1'b0}}, c[HALF_W-1:0]};
    if (sp) return {{HALF_W{1'b0}}, c[CTR_W-1:HALF_W]};
    return c;
  endfunction

  // New physical value after a logical write: only the viewed bits change.
  function automatic logic [CTR_W-1:0] lmerge(
    input logic [CTR_W-1:0] c,
    input logic [CTR_W-1:0] w,
    input logic             lo,
    input logic             sp
  );
    if (lo) return {c[CTR_W-1:HALF_W], w[HALF_W-1:0]};
    if (sp) return {w[HALF_W-1:0], c[HALF_W-1:0]};
    return w;
  endfunction

  // ---------------- address decode ----------------
  assign slot   = bus_addr[ADDR_W-1:3];
  assign lidx   = slot - SLOT_W'(SLOT_CTR0);
  assign pidx   = lidx[PIDX_W-1:0];
  assign lo_sel = lidx[PIDX_W];
  assign wv     = bus_wdata[BUS_W-1:CTR_W];

  always_comb begin
    kind = ACC_NONE;
    if (slot == SLOT_W'(SLOT_CTRL)) begin
      kind = ACC_CTRL;
    end else if (slot == SLOT_W'(SLOT_STAT)) begin
      kind = ACC_STAT;
    end else if (slot >= SLOT_W'(SLOT_CTR0) &&
                 slot <  SLOT_W'(SLOT_CTR0 + NUM_LOG)) begin
      kind = ACC_CTR;
    end
  end

  // ---------------- control word ----------------
  assign commit   = bus_wr && (kind == ACC_CTRL) && wv[CTRL_EN_BIT];
  assign count_en = ctrl_q[CTRL_EN_BIT];
  assign stat_rd  = bus_rd && (kind == ACC_STAT);
  assign mask_wr  = bus_wr && (kind == ACC_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (bus_wr && kind == ACC_CTRL) begin
      ctrl_q <= wv & CTRL_MASK;
    end
  end

  // ---------------- physical counters ----------------
  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
    assign split[p]  = ctrl_q[CTRL_SPLIT_LSB + p];
    assign cur[p]    = pend[p] ? latch_v[p] : live[p];
    assign wr_hit[p] = bus_wr && (kind == ACC_CTR) && (pidx == PIDX_W'(p));
    assign wr_val[p] = lmerge(cur[p], wv, lo_sel, split[p]);

    pcu_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .split     (split[p]),
      .count_en  (count_en),
      .ev_hi     (event_in[p]),
      .ev_lo     (event_in[p + NUM_PHYS]),
      .wr_en     (wr_hit[p]),
      .wr_val    (wr_val[p]),
      .commit    (commit),
      .live      (live[p]),
      .latch_val (latch_v[p]),
      .pend      (pend[p]),
      .ovf_hi    (ovf_set[p]),
      .ovf_lo    (ovf_set[p + NUM_PHYS])
    );
  end

  // ---------------- status and interrupt ----------------
  pcu_status #(.NUM_LOG(NUM_LOG)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_set  (ovf_set),
    .rd_clr   (stat_rd),
    .mask_wr  (mask_wr),
    .mask_val (wv[NUM_LOG-1:0]),
    .status   (status),
    .mask     (mask),
    .irq      (irq)
  );

  // ---------------- read path ----------------
  always_comb begin
    rsel = '0;
    case (kind)
      ACC_CTRL: rsel = ctrl_q;
      ACC_STAT: rsel = CTR_W'(status);
      ACC_CTR:  rsel = lview(cur[pidx], lo_sel, split[pidx]);
      default:  rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= {rsel, {CTR_W{1'b0}}};
    end
  end

  assign bus_rdata = rdata_q;

  // R8: every enable write empties all pending flags
  p_flags_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (pend == '0));

  // R2: lower bus half of returned data is zero after a read
  p_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_rdata[CTR_W-1:0] == '0));
endmodule

// File: tb/perf_ctr_unit_tb.sv
module perf_ctr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [7:0]  ev = '0;
  logic        irq;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  perf_ctr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .event_in(ev), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int slot, input logic [31:0] v);
    @(negedge clk);
    addr = 8'(slot << 3); wdata = {v, 32'h0}; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_raw(input int slot, output logic [63:0] d);
    @(negedge clk);
    addr = 8'(slot << 3); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd_reg(input int slot, output logic [31:0] v);
    logic [63:0] d;
    rd_raw(slot, d);
    v = d[63:32];
  endtask

  task automatic ev_cycles(input logic [7:0] v, input int n);
    @(negedge clk);
    ev = v;
    repeat (n) @(negedge clk);
    ev = '0;
  endtask

  // Logical counter n lives in slot 2+n.
  function automatic int cs(input int n);
    return 2 + n;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] d;
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {63'h0, irq}, 64'h0);
    rd_raw(0, d); check("R1 ctrl", d, 64'h0);
    rd_raw(1, d); check("R1 status", d, 64'h0);
    for (int n = 0; n < 8; n++) begin
      rd_raw(cs(n), d); check("R1 counter", d, 64'h0);
    end

    // R2 unmapped slot and lower-half zero
    wr_reg(cs(0), 32'hCAFE_0001);
    rd_raw(15, d); check("R2 unmapped", d, 64'h0);
    rd_raw(cs(0), d); check("R2 layout", d, {32'hCAFE_0001, 32'h0});

    // R4 R6 R7 32-bit mode on every physical counter
    for (int i = 0; i < 4; i++) begin
      a = 32'h0100_0000 * (i + 1) + 32'h0000_1000;
      wr_reg(0, 32'h0);
      wr_reg(cs(i), a);
      rd_reg(cs(i), v); check("R7 latched read", {32'h0, v}, {32'h0, a});
      rd_reg(cs(4 + i), v); check("R6 low view 32", {32'h0, v}, {48'h0, a[15:0]});
      wr_reg(0, 32'h1);
      ev_cycles(8'((1 << i) | (1 << (4 + i))), i + 3);
      rd_reg(cs(i), v); check("R4 count 32", {32'h0, v}, {32'h0, a + 32'(i + 3)});
      rd_reg(cs(4 + i), v);
      check("R6 low after count", {32'h0, v}, {48'h0, 16'(a + 32'(i + 3))});
    end

    // R5 R6 16-bit halves
    for (int i = 0; i < 4; i++) begin
      wr_reg(0, 32'(1 << (4 + i)));
      wr_reg(cs(i), 32'h0A00 + 32'(i));
      wr_reg(cs(4 + i), 32'h00F0 + 32'(i));
      rd_reg(cs(i), v); check("R6 upper view", {32'h0, v}, {32'h0, 32'h0A00 + 32'(i)});
      rd_reg(cs(4 + i), v); check("R6 lower view", {32'h0, v}, {32'h0, 32'h00F0 + 32'(i)});
      wr_reg(0, 32'(1 << (4 + i)) | 32'h1);
      ev_cycles(8'((1 << i) | (1 << (4 + i))), 3);
      ev_cycles(8'(1 << (4 + i)), 2);
      rd_reg(cs(i), v); check("R5 upper count", {32'h0, v}, {32'h0, 32'h0A03 + 32'(i)});
      rd_reg(cs(4 + i), v); check("R5 lower count", {32'h0, v}, {32'h0, 32'h00F5 + 32'(i)});
    end

    // R5 no carry, R9 low-half overflow bit, R10 clear on read
    for (int i = 0; i < 4; i++) begin
      wr_reg(0, 32'(1 << (4 + i)));
      wr_reg(cs(4 + i), 32'hFFFF);
      wr_reg(cs(i), 32'h0007);
      wr_reg(0, 32'(1 << (4 + i)) | 32'h1);
      rd_reg(1, v);
      ev_cycles(8'(1 << (4 + i)), 1);
      rd_reg(cs(i), v); check("R5 no carry upper", {32'h0, v}, 64'h7);
      rd_reg(cs(4 + i), v); check("R5 lower wrapped", {32'h0, v}, 64'h0);
      rd_reg(1, v); check("R9 low ovf bit", {32'h0, v}, {32'h0, 32'(1 << (4 + i))});
      rd_reg(1, v); check("R10 cleared", {32'h0, v}, 64'h0);
    end

    // R9 32-bit wrap
    for (int i = 0; i < 4; i++) begin
      wr_reg(0, 32'h0);
      wr_reg(cs(i), 32'hFFFF_FFFE);
      wr_reg(0, 32'h1);
      rd_reg(1, v);
      ev_cycles(8'(1 << i), 3);
      rd_reg(cs(i), v); check("R9 wrapped value", {32'h0, v}, 64'h1);
      rd_reg(1, v); check("R9 32 ovf bit", {32'h0, v}, {32'h0, 32'(1 << i)});
    end

    // R7 live keeps running under a staged write
    wr_reg(0, 32'h0);
    wr_reg(cs(0), 32'hFFFF_FFFE);
    wr_reg(0, 32'h1);
    rd_reg(1, v);
    wr_reg(cs(0), 32'h0000_0100);
    ev_cycles(8'h01, 2);
    rd_reg(cs(0), v); check("R7 pending view", {32'h0, v}, 64'h100);
    rd_reg(1, v); check("R7 live wrapped", {32'h0, v}, 64'h1);
    wr_reg(0, 32'h1);
    rd_reg(cs(0), v); check("R8 recommit", {32'h0, v}, 64'h100);

    // R8 commit wins over same-cycle event
    wr_reg(cs(0), 32'h0000_0500);
    @(negedge clk);
    addr = 8'(0); wdata = {32'h1, 32'h0}; wr = 1'b1; ev = 8'h01;
    @(negedge clk);
    wr = 1'b0; ev = '0;
    rd_reg(cs(0), v); check("R8 commit wins", {32'h0, v}, 64'h500);

    // R4 no counting while disabled
    wr_reg(cs(1), 32'h77);
    wr_reg(0, 32'h1);
    wr_reg(0, 32'h0);
    ev_cycles(8'h02, 4);
    rd_reg(cs(1), v); check("R4 disabled hold", {32'h0, v}, 64'h77);

    // R11 mask and irq
    wr_reg(cs(2), 32'hFFFF_FFFF);
    wr_reg(0, 32'h1);
    rd_reg(1, v);
    ev_cycles(8'h04, 1);
    check("R11 masked off", {63'h0, irq}, 64'h0);
    wr_reg(1, 32'h04); check("R11 irq on", {63'h0, irq}, 64'h1);
    wr_reg(1, 32'h02); check("R11 other bit", {63'h0, irq}, 64'h0);
    wr_reg(1, 32'hFF); check("R11 all bits", {63'h0, irq}, 64'h1);
    wr_reg(1, 32'h00); check("R11 zero mask", {63'h0, irq}, 64'h0);
    wr_reg(1, 32'h04);
    rd_reg(1, v); check("R10 status kept by writes", {32'h0, v}, 64'h4);
    check("R11 irq after clear", {63'h0, irq}, 64'h0);

    // R10 overflow in the read cycle survives
    wr_reg(cs(3), 32'hFFFF_FFFF);
    wr_reg(0, 32'h1);
    @(negedge clk);
    addr = 8'(1 << 3); rd = 1'b1; ev = 8'h08;
    @(negedge clk);
    rd = 1'b0; ev = '0;
    check("R10 read before ovf", rdata, 64'h0);
    rd_reg(1, v); check("R10 same-cycle ovf kept", {32'h0, v}, 64'h8);

    // R3 control fields
    wr_reg(0, 32'hFFFF_FFFF);
    rd_reg(0, v); check("R3 ctrl bits", {32'h0, v}, 64'hF1);
    wr_reg(0, 32'h0000_0050);
    rd_reg(0, v); check("R3 split only", {32'h0, v}, 64'h50);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule